// File: doc/BRIEF.md
# Dual-Integrator Ping-Pong Conversion Scheduler

This block schedules a pair of integrator sides that share one converter. One side collects charge for a programmed number of system clocks. When that period ends, the sides swap: the other side starts integrating, and the converter digitizes the side that just finished and then clears it. One conversion cycle handles two signals, and each signal has a convert phase followed by an integrator-reset phase. The cycle therefore lasts twice the sum of the convert count and the reset count.

When a conversion cycle fits inside one integration period, integration runs without a break. The swap strobe then pulses exactly once per period and can serve as the external conversion edge. When the conversion cycle is longer than the integration period, the scheduler halts integration at the end of each period. It restarts on the first clock after the converter is free, and it raises a flag reporting non-continuous operation. The scheduler is idle after reset and starts on a one-clock start pulse. The three counts are held stable while it runs, and each of them is at least 1.

Top module: `pingpong_sched`

## Requirements
- R1: While `rst` is high and after it, until a `start` pulse arrives, all outputs are 0: `side` = 0 (side A), and `integ_en`, `period_done`, `cvt_start`, `ireset` and `noncont` are low.
- R2: A `start` pulse sampled on a clock edge raises `integ_en` in the next cycle on side A. The first window lasts exactly `int_len` cycles.
- R3: The conversion cycle lasts L = 2*(`cvt_len` + `rst_len`) cycles. It is launched in the same cycle in which `period_done` is high.
- R4: Counting from 0 at the launch cycle, `cvt_start` is high for exactly one cycle at offset 0 and one cycle at offset `cvt_len`+`rst_len`, and low at every other offset.
- R5: `ireset` is high at offsets `cvt_len` .. `cvt_len`+`rst_len`-1 and 2*`cvt_len`+`rst_len` .. L-1 of a conversion cycle, and low at every other offset.
- R6: If `int_len` >= L, `integ_en` stays high without a gap after start. `side` toggles every `int_len` cycles, and `period_done` is high for one cycle at each toggle.
- R7: If `int_len` < L, `integ_en` drops after every window except the first, for L - `int_len` cycles. `noncont` goes high in the first gap cycle and stays high.
- R8: In non-continuous operation, integration restarts in the cycle after the converter's last cycle. At that point `side` toggles and `period_done` is high for that one cycle.
- R9: The first period end always swaps with no gap, because the converter is idle at that point. `noncont` therefore stays low until the second window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins scheduling |
| int_len | input | CW | Integration period in clocks (>= 1) |
| cvt_len | input | CW | Convert phase length per signal in clocks (>= 1) |
| rst_len | input | CW | Integrator reset phase length per signal in clocks (>= 1) |
| side | output | 1 | Integrating side: 0 = A, 1 = B |
| integ_en | output | 1 | Integration active on `side` |
| cvt_start | output | 1 | Start of a convert phase |
| ireset | output | 1 | Integrator reset phase active |
| period_done | output | 1 | One-cycle swap strobe |
| noncont | output | 1 | Non-continuous operation flag |

## Verification
Every result is referenced to the edge that samples `start`. `integ_en` rises in the next cycle. Each swap and conversion launch appears in the cycle after the edge that ends a window. Conversion strobes follow at fixed offsets from that launch cycle, and `noncont` rises in the first cycle of a gap. For each scenario the bench turns the requirements into a per-cycle table of all six outputs. It puts that table in a queue before start, and a monitor starts popping exactly one cycle after the sampling edge, comparing at the falling edge. Periods are swept at L, above L, one below L, far below L and at 1, so that the gap length and the first-swap exception are both exercised.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;
    parameter int CW = 16;
    localparam int LW = CW + 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INTEG = 2'd1,
        PH_HOLD  = 2'd2
    } phase_t;

    // length of one conversion cycle: two signals, each convert + reset
    function automatic logic [LW-1:0] cycle_len(input logic [CW-1:0] c,
                                                input logic [CW-1:0] r);
        return LW'(2) * (LW'(c) + LW'(r));
    endfunction

    function automatic logic [LW-1:0] half_len(input logic [CW-1:0] c,
                                               input logic [CW-1:0] r);
        return LW'(c) + LW'(r);
    endfunction
endpackage

// File: rtl/conv_engine.sv
module conv_engine
    import pingpong_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [CW-1:0] cvt_len,
    input  logic [CW-1:0] rst_len,
    output logic          free,
    output logic          cvt_start,
    output logic          ireset
);
    logic          busy;
    logic [LW-1:0] cc;
    logic [LW-1:0] full;
    logic [LW-1:0] half;
    logic [LW-1:0] pos;
    logic          last;

    assign full = cycle_len(cvt_len, rst_len);
    assign half = half_len(cvt_len, rst_len);
    assign last = busy && (cc == full - LW'(1));
    assign free = !busy || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cc   <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cc   <= '0;
        end else if (last) begin
            busy <= 1'b0;
            cc   <= '0;
        end else if (busy) begin
            cc <= cc + LW'(1);
        end
    end

    // position inside the current signal slot
    assign pos       = (cc < half) ? cc : cc - half;
    assign cvt_start = busy && ((cc == '0) || (cc == half));
    assign ireset    = busy && (pos >= LW'(cvt_len));
endmodule

// File: rtl/period_ctrl.sv
module period_ctrl
    import pingpong_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] int_len,
    input  logic          conv_free,
    output logic          launch,
    output logic          side,
    output logic          integ_en,
    output logic          period_done,
    output logic          noncont
);
    phase_t        ph;
    logic [CW-1:0] ic;
    logic          win_end;

    assign win_end  = (ph == PH_INTEG) && (ic == int_len - CW'(1));
    assign launch   = conv_free && (win_end || (ph == PH_HOLD));
    assign integ_en = (ph == PH_INTEG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            ic          <= '0;
            side        <= 1'b0;
            period_done <= 1'b0;
            noncont     <= 1'b0;
        end else begin
            period_done <= launch;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph <= PH_INTEG;
                        ic <= '0;
                    end
                end
                PH_INTEG: begin
                    if (win_end) begin
                        ic <= '0;
                        if (conv_free) begin
                            side    <= ~side;
                            noncont <= 1'b0;
                        end else begin
                            ph      <= PH_HOLD;
                            noncont <= 1'b1;
                        end
                    end else begin
                        ic <= ic + CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (conv_free) begin
                        ph   <= PH_INTEG;
                        side <= ~side;
                        ic   <= '0;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pingpong_sched.sv
module pingpong_sched
    import pingpong_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] int_len,
    input  logic [CW-1:0] cvt_len,
    input  logic [CW-1:0] rst_len,
    output logic          side,
    output logic          integ_en,
    output logic          cvt_start,
    output logic          ireset,
    output logic          period_done,
    output logic          noncont
);
    logic launch;
    logic conv_free;

    period_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .int_len     (int_len),
        .conv_free   (conv_free),
        .launch      (launch),
        .side        (side),
        .integ_en    (integ_en),
        .period_done (period_done),
        .noncont     (noncont)
    );

    conv_engine u_conv (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .cvt_len   (cvt_len),
        .rst_len   (rst_len),
        .free      (conv_free),
        .cvt_start (cvt_start),
        .ireset    (ireset)
    );
endmodule

// File: rtl/pingpong_sched_chk.sv
module pingpong_sched_chk (
    input logic clk,
    input logic rst,
    input logic side,
    input logic integ_en,
    input logic cvt_start,
    input logic ireset,
    input logic period_done,
    input logic noncont
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!side && !integ_en && !cvt_start && !ireset && !period_done && !noncont));

    a_r3_launch_with_swap: assert property (@(posedge clk) disable iff (rst)
        period_done |-> cvt_start);

    a_r6_swap_toggles_side: assert property (@(posedge clk) disable iff (rst)
        period_done |-> (side != $past(side)));

    a_r7_gap_only_noncont: assert property (@(posedge clk) disable iff (rst)
        $fell(integ_en) |-> noncont);

    a_r8_restart_strobe: assert property (@(posedge clk) disable iff (rst)
        (noncont && $rose(integ_en)) |-> period_done);

    a_r4_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        cvt_start |-> !ireset);
endmodule

bind pingpong_sched pingpong_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .side        (side),
    .integ_en    (integ_en),
    .cvt_start   (cvt_start),
    .ireset      (ireset),
    .period_done (period_done),
    .noncont     (noncont)
);

// File: tb/tb_pingpong_sched.sv
module tb_pingpong_sched;
    import pingpong_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 90;

    typedef struct packed {
        logic ie;
        logic sd;
        logic pd;
        logic nc;
        logic cs;
        logic ir;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] int_len = CW'(4);
    logic [CW-1:0] cvt_len = CW'(3);
    logic [CW-1:0] rst_len = CW'(2);
    logic side, integ_en, cvt_start, ireset, period_done, noncont;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];
    logic mon_on = 1'b0;
    string scen = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    pingpong_sched dut (
        .clk(clk), .rst(rst), .start(start),
        .int_len(int_len), .cvt_len(cvt_len), .rst_len(rst_len),
        .side(side), .integ_en(integ_en), .cvt_start(cvt_start),
        .ireset(ireset), .period_done(period_done), .noncont(noncont)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s %s: actual %0b expected %0b at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    // monitor: one popped item per cycle, compared at the falling edge
    always @(negedge clk) begin
        if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R2", "integ_en", integ_en, e.ie);   // window timing, also R6/R7 gaps
            chk("R6", "side", side, e.sd);
            chk("R8", "period_done", period_done, e.pd);
            chk("R7", "noncont", noncont, e.nc);     // first-window exception R9
            chk("R4", "cvt_start", cvt_start, e.cs); // launch aligned to swap R3
            chk("R5", "ireset", ireset, e.ir);
        end
    end

    // driver: expected per-cycle table built from the requirements
    task automatic run_case(input int il, input int cl, input int rl, input string name);
        exp_t tbl[NCYC];
        int s, k, ln, h;
        scen = name;
        ln = 2 * (cl + rl);
        h  = cl + rl;
        for (int t = 0; t < NCYC; t++) tbl[t] = '0;
        s = 0;
        k = 0;
        while (s < NCYC) begin
            for (int t = s; t < NCYC; t++) tbl[t].sd = k[0];
            for (int t = s; t < s + il && t < NCYC; t++) tbl[t].ie = 1'b1;
            if (k >= 1) begin
                tbl[s].pd = 1'b1;
                tbl[s].cs = 1'b1;
                if (s + h < NCYC) tbl[s + h].cs = 1'b1;
                for (int t = s + cl; t < s + h && t < NCYC; t++) tbl[t].ir = 1'b1;
                for (int t = s + h + cl; t < s + ln && t < NCYC; t++) tbl[t].ir = 1'b1;
                if (ln > il)
                    for (int t = s + il; t < NCYC; t++) tbl[t].nc = 1'b1;
            end
            s = (k == 0) ? il : s + ((il > ln) ? il : ln);
            k++;
        end
        @(negedge clk);
        rst = 1'b1;
        int_len = CW'(il);
        cvt_len = CW'(cl);
        rst_len = CW'(rl);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int t = 0; t < NCYC; t++) sb_q.push_back(tbl[t]);
        start = 1'b1;
        @(posedge clk);
        #1;
        start  = 1'b0;
        mon_on = 1'b1;
        while (sb_q.size() > 0) @(posedge clk);
        #1;
        mon_on = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        scen = "reset";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle with no start for several cycles after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "side", side, 1'b0);
            chk("R1", "integ_en", integ_en, 1'b0);
            chk("R1", "period_done", period_done, 1'b0);
            chk("R1", "cvt_start", cvt_start, 1'b0);
            chk("R1", "ireset", ireset, 1'b0);
            chk("R1", "noncont", noncont, 1'b0);
        end
        run_case(10, 3, 2, "I_eq_L");     // R6 boundary
        run_case(14, 3, 2, "I_above_L");  // R6
        run_case(9, 3, 2, "I_L_minus1");  // R7 gap of 1
        run_case(4, 3, 2, "I_far_below"); // R7, R8 gap of 6
        run_case(1, 3, 2, "I_one");       // R9 first swap without gap
        run_case(3, 1, 1, "short_conv");  // R7 with L=4
        run_case(4, 1, 1, "short_eq");    // R6 boundary with L=4
        // R1 again: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        scen = "reset2";
        chk("R1", "integ_en", integ_en, 1'b0);
        chk("R1", "side", side, 1'b0);
        chk("R1", "noncont", noncont, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule